// File: doc/BRIEF.md
# Serial Register Control Port

This block is a four-wire serial slave that gives an external host write and read access to a small bank of 8-bit control registers. The host lowers the latch line, clocks in a 24-bit frame most significant bit first, and raises the latch again. The frame is made of three bytes. The first byte carries a 7-bit device address and a read/write flag. The second byte is the register index. The third byte is the write data, or, for a read, the slot in which the block shifts the register contents back out. The bank is exposed on a flat output bus to the rest of the chip.

The serial bit clock, latch and data pins are treated as asynchronous. They are brought into the system clock domain through two-stage synchronizers, and their edges are found there. The host's bit clock must therefore be slow compared with the system clock: each half period must last at least eight system clocks.

While reset is held, the latch pin also serves as a strap. If the latch is pulled high, a host is present and serial control is used. If it is low, the block enters a standalone configuration. In that configuration the registers take their defaults with two exceptions: the master-clock enable is forced on, and the converter-clock master/slave bit copies the level of the serial-out pad. Serial frames are ignored in standalone mode.

Top module: `ctl_spi_regbank`

## Requirements
- R1: After a reset with the latch pin high, register i (i = 0..7) holds the default value {i[3:0], 4'h0}, and `reg_bank_o[8*i +: 8]` shows register i.
- R2: The latch level during the last reset cycle selects the mode: high gives host mode (`standalone_o` = 0), low gives standalone mode (`standalone_o` = 1). The mode does not change until the next reset.
- R3: In standalone mode, register 0 bit 7 (master-clock enable) is 1, and register 6 bit 0 (converter-clock master select) equals `sdo_pad_i` as sampled during reset. All other bits keep their defaults. Serial frames neither change any register nor enable the serial output.
- R4: A frame is made of bits sampled on rising edges of `sck_i` while `cs_n_i` is low, most significant bit first. Bits 23:17 are the device address (7'h04), bit 16 is the flag (0 = write, 1 = read), bits 15:8 are the register index and bits 7:0 are the data. A write header byte is therefore 0x08 and a read header byte is 0x09.
- R5: A write frame takes effect when `cs_n_i` rises, and only if exactly 24 bits were received, the device address matches and the flag is 0. Registers change at no other time.
- R6: A frame of any bit count other than 24, shorter or longer, changes no register.
- R7: A frame with a device address other than 7'h04 changes no register and never enables `sdo_o`.
- R8: On a read frame with a matching address, the addressed register is shifted out on `sdo_o` during the third byte, most significant bit first. Each bit changes after a falling edge of `sck_i` and is valid at the next rising edge. `sdo_oe_o` is high only from the third byte onward.
- R9: Register indices of 8 and above read back as 0x00, and writes to them change nothing.
- R10: `sdo_oe_o` is low whenever the latch has been high for at least four system clocks.
- R11: A read frame does not modify the register it reads, whatever data bits the host sends in the third byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| cs_n_i | input | 1 | Serial latch (active-low frame select); also the host-present strap |
| sck_i | input | 1 | Serial bit clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_pad_i | input | 1 | Level of the serial-out pad, used as the master-select strap during reset |
| sdo_o | output | 1 | Serial read data to the host |
| sdo_oe_o | output | 1 | Output enable for the serial-out pad driver (low = high impedance) |
| standalone_o | output | 1 | High when the standalone configuration was selected at reset |
| reg_bank_o | output | NUM_REGS*8 | Flat view of the register bank, register i in bits 8*i+7:8*i |

## Verification
The assertions check on every cycle that registers change only in the cycle after a latch rise that closes a 24-bit frame, and that nothing moves in standalone mode. They also check that the mode flag stays stable after reset, that the master-clock enable stays forced on in standalone mode, and that the output enable never stays up while the latch is high or before the header bytes are complete. Whether the right register gets the right byte, whether read data comes out in the right order, and whether short, long, misaddressed and out-of-range frames are rejected can only be shown by the bench's frame scenarios, checked against its own register model.

// File: rtl/ctl_spi_pkg.sv
// Package: shared constants and the register default function for the
// serial register control port. Assumes registers are one byte wide.
package ctl_spi_pkg;
    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 3 * BYTE_W;   // header, index, data
    localparam int HDR_BITS   = 2 * BYTE_W;   // bits before the data byte

    // Default contents of register idx: index in the upper nibble
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        return BYTE_W'((idx & 15) << 4);
    endfunction
endpackage

// File: rtl/ctl_spi_sync.sv
// Module: two-stage synchronizer for a group of asynchronous pins.
// Assumes the pins change slowly compared with clk; each bit is
// synchronized on its own and takes the reset value RST_VAL.
module ctl_spi_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two flops in series per pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/ctl_spi_frame.sv
// Module: serial frame receiver. Finds bit-clock and latch edges on
// synchronized pins, shifts in data on bit-clock rises while the latch
// is low, and counts bits with saturation. Assumes sdi and sck pass
// through the same synchronizer so they keep their relative timing.
module ctl_spi_frame #(
    parameter int FRAME_BITS = 24,
    parameter int CNT_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_s_i,
    input  logic                  sck_s_i,
    input  logic                  sdi_s_i,
    output logic                  sck_rise_o,
    output logic                  sck_fall_o,
    output logic                  cs_rise_o,
    output logic [CNT_W-1:0]      bit_cnt_o,
    output logic [FRAME_BITS-1:0] shift_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                  sck_d_q;
    logic                  cs_d_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-1:0] shift_q;

    // Delayed copies of the pins for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d_q <= 1'b0;
            cs_d_q  <= 1'b1;
        end else begin
            sck_d_q <= sck_s_i;
            cs_d_q  <= cs_n_s_i;
        end
    end

    assign sck_rise_o = sck_s_i & ~sck_d_q & ~cs_n_s_i;
    assign sck_fall_o = ~sck_s_i & sck_d_q & ~cs_n_s_i;
    assign cs_rise_o  = cs_n_s_i & ~cs_d_q;

    // Bit counter: cleared while the latch is high, saturates at its maximum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cs_n_s_i) begin
            cnt_q <= '0;
        end else if (sck_rise_o && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Input shift register, most significant bit arrives first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (sck_rise_o) begin
            shift_q <= {shift_q[FRAME_BITS-2:0], sdi_s_i};
        end
    end

    assign bit_cnt_o = cnt_q;
    assign shift_o   = shift_q;
endmodule

// File: rtl/ctl_spi_regfile.sv
// Module: control register bank with strap-dependent reset values.
// While rst_n is low it loads defaults and records the mode from the
// latch strap; in standalone mode two bits are overridden. One write
// port, one combinational read port; indices beyond the bank read zero.
module ctl_spi_regfile
    import ctl_spi_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int ADDR_W      = 8,
    parameter int CLK_REG     = 0,
    parameter int MCLK_EN_BIT = 7,
    parameter int ADC_REG     = 6,
    parameter int ADC_MS_BIT  = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       strap_cs_n_i,
    input  logic                       strap_sdo_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [BYTE_W-1:0]          wr_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic                       standalone_o,
    output logic [NUM_REGS*BYTE_W-1:0] bank_o
);
    logic standalone_q;

    // Reset value of register idx for the strap levels now on the pins
    function automatic logic [BYTE_W-1:0] reset_value(input int idx,
                                                      input logic alone,
                                                      input logic ms);
        logic [BYTE_W-1:0] v;
        v = reg_default(idx);
        if (alone && (idx == CLK_REG)) v[MCLK_EN_BIT] = 1'b1;
        if (alone && (idx == ADC_REG)) v[ADC_MS_BIT]  = ms;
        return v;
    endfunction

    // Mode strap: latch low during reset means no host is present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            standalone_q <= ~strap_cs_n_i;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [BYTE_W-1:0] q;

            // One register: strap-aware reset, load on a decoded write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= reset_value(g, ~strap_cs_n_i, strap_sdo_i);
                end else if (wr_en_i && (wr_addr_i == ADDR_W'(g))) begin
                    q <= wr_data_i;
                end
            end

            assign bank_o[g*BYTE_W +: BYTE_W] = q;
        end
    endgenerate

    // Read mux: unmatched indices give zero
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_i == ADDR_W'(i)) rd_data_o = bank_o[i*BYTE_W +: BYTE_W];
        end
    end

    assign standalone_o = standalone_q;
endmodule

// File: rtl/ctl_spi_tx.sv
// Module: read-data serializer. Loads the read byte on the bit-clock
// fall that follows the second byte of a valid read header, then
// shifts one bit per fall. Drops its enable once the latch is high.
module ctl_spi_tx
    import ctl_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s_i,
    input  logic              sck_fall_i,
    input  logic              load_ok_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    logic [BYTE_W-1:0] tx_q;
    logic              act_q;

    // Load on the first data-slot fall, shift on later falls
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s_i) begin
            tx_q  <= '0;
            act_q <= 1'b0;
        end else if (sck_fall_i) begin
            if (load_ok_i) begin
                tx_q  <= rd_data_i;
                act_q <= 1'b1;
            end else if (act_q) begin
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign sdo_o    = act_q & tx_q[BYTE_W-1];
    assign sdo_oe_o = act_q;
endmodule

// File: rtl/ctl_spi_regbank.sv
// Module: top of the serial register control port. Synchronizes the
// serial pins, receives 24-bit frames, decodes device address and
// read/write flag, and drives the register bank and read serializer.
// Assumes each sck half period spans at least eight clk cycles.
module ctl_spi_regbank
    import ctl_spi_pkg::*;
#(
    parameter int          NUM_REGS    = 8,
    parameter logic [6:0]  DEV_ADDR    = 7'h04,
    parameter int          CLK_REG     = 0,
    parameter int          MCLK_EN_BIT = 7,
    parameter int          ADC_REG     = 6,
    parameter int          ADC_MS_BIT  = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n_i,
    input  logic                       sck_i,
    input  logic                       sdi_i,
    input  logic                       sdo_pad_i,
    output logic                       sdo_o,
    output logic                       sdo_oe_o,
    output logic                       standalone_o,
    output logic [NUM_REGS*BYTE_W-1:0] reg_bank_o
);
    localparam int ADDR_W = BYTE_W;
    localparam int CNT_W  = $clog2(FRAME_BITS + 2);

    logic                  cs_n_s_w, sck_s_w, sdi_s_w;
    logic                  sck_rise_w, sck_fall_w, cs_rise_w;
    logic [CNT_W-1:0]      bit_cnt_w;
    logic [FRAME_BITS-1:0] shift_w;
    logic                  hdr_match_w, rd_load_w, wr_en_w;
    logic [BYTE_W-1:0]     rd_data_w;

    ctl_spi_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, sck_i, sdi_i}),
        .q_o   ({cs_n_s_w, sck_s_w, sdi_s_w})
    );

    ctl_spi_frame #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s_i   (cs_n_s_w),
        .sck_s_i    (sck_s_w),
        .sdi_s_i    (sdi_s_w),
        .sck_rise_o (sck_rise_w),
        .sck_fall_o (sck_fall_w),
        .cs_rise_o  (cs_rise_w),
        .bit_cnt_o  (bit_cnt_w),
        .shift_o    (shift_w)
    );

    // Read decode after two bytes: header in [15:8], index in [7:0]
    assign hdr_match_w = (shift_w[HDR_BITS-1 -: 7] == DEV_ADDR);
    assign rd_load_w   = (bit_cnt_w == CNT_W'(HDR_BITS)) && hdr_match_w
                         && shift_w[BYTE_W] && !standalone_o;

    // Write decode at latch rise after a full frame
    assign wr_en_w = cs_rise_w && (bit_cnt_w == CNT_W'(FRAME_BITS))
                     && (shift_w[FRAME_BITS-1 -: 7] == DEV_ADDR)
                     && !shift_w[HDR_BITS] && !standalone_o;

    ctl_spi_regfile #(
        .NUM_REGS    (NUM_REGS),
        .ADDR_W      (ADDR_W),
        .CLK_REG     (CLK_REG),
        .MCLK_EN_BIT (MCLK_EN_BIT),
        .ADC_REG     (ADC_REG),
        .ADC_MS_BIT  (ADC_MS_BIT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_cs_n_i (cs_n_i),
        .strap_sdo_i  (sdo_pad_i),
        .wr_en_i      (wr_en_w),
        .wr_addr_i    (shift_w[HDR_BITS-1 -: ADDR_W]),
        .wr_data_i    (shift_w[BYTE_W-1:0]),
        .rd_addr_i    (shift_w[ADDR_W-1:0]),
        .rd_data_o    (rd_data_w),
        .standalone_o (standalone_o),
        .bank_o       (reg_bank_o)
    );

    ctl_spi_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s_i   (cs_n_s_w),
        .sck_fall_i (sck_fall_w),
        .load_ok_i  (rd_load_w),
        .rd_data_i  (rd_data_w),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o)
    );
endmodule

// File: rtl/ctl_spi_regbank_chk.sv
// Module: assertion checker for ctl_spi_regbank, attached by bind.
// Assumes reset is held for at least two clock cycles at start-up.
module ctl_spi_regbank_chk #(
    parameter int NUM_REGS    = 8,
    parameter int CNT_W       = 5,
    parameter int CLK_REG     = 0,
    parameter int MCLK_EN_BIT = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n_i,
    input logic                  sdo_oe_o,
    input logic                  standalone_o,
    input logic [NUM_REGS*8-1:0] reg_bank_o,
    input logic                  cs_rise,
    input logic [CNT_W-1:0]      bit_cnt
);
    // R10: latch high for four clocks forces the output enable off
    a_r10_oe_off_latch_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_oe_o);

    // R8: output enabled only once the two header bytes are in
    a_r8_oe_after_header: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o |-> (bit_cnt >= CNT_W'(16)));

    // R5: registers move only right after a latch rise closing 24 bits
    a_r5_write_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(reg_bank_o)) |-> $past(cs_rise && (bit_cnt == CNT_W'(24))));

    // R3: standalone mode leaves the bank untouched
    a_r3_standalone_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (standalone_o && $past(rst_n)) |-> $stable(reg_bank_o));

    // R3: master-clock enable held on in standalone mode
    a_r3_mclk_forced: assert property (@(posedge clk) disable iff (!rst_n)
        standalone_o |-> reg_bank_o[CLK_REG*8 + MCLK_EN_BIT]);

    // R2: mode fixed between resets
    a_r2_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(standalone_o));
endmodule

bind ctl_spi_regbank ctl_spi_regbank_chk #(
    .NUM_REGS    (NUM_REGS),
    .CNT_W       (CNT_W),
    .CLK_REG     (CLK_REG),
    .MCLK_EN_BIT (MCLK_EN_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n_i),
    .sdo_oe_o     (sdo_oe_o),
    .standalone_o (standalone_o),
    .reg_bank_o   (reg_bank_o),
    .cs_rise      (cs_rise_w),
    .bit_cnt      (bit_cnt_w)
);

// File: tb/ctl_spi_regbank_bench.sv
// Bench: scoreboard for the serial register control port. The frame
// driver pushes expected read bytes; a monitor on sck captures sdo_o
// and compares. Register contents are checked against a local model.
module ctl_spi_regbank_bench;
    localparam int NREG = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cs_n_i = 1'b1;
    logic            sck_i = 1'b0;
    logic            sdi_i = 1'b0;
    logic            sdo_pad_i = 1'b0;
    logic            sdo_o, sdo_oe_o, standalone_o;
    logic [NREG*8-1:0] reg_bank_o;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    bit   oe_seen = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;   // 50 MHz

    ctl_spi_regbank u_ctl_spi_regbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (cs_n_i),
        .sck_i        (sck_i),
        .sdi_i        (sdi_i),
        .sdo_pad_i    (sdo_pad_i),
        .sdo_o        (sdo_o),
        .sdo_oe_o     (sdo_oe_o),
        .standalone_o (standalone_o),
        .reg_bank_o   (reg_bank_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(tag, 32'(reg_bank_o[i*8 +: 8]), 32'(model[i]));
    endtask

    task automatic set_defaults();
        for (int i = 0; i < NREG; i++) model[i] = 8'((i & 15) << 4);
    endtask

    task automatic do_reset(input logic cs_lvl, input logic pad);
        @(negedge clk);
        rst_n = 1'b0; cs_n_i = cs_lvl; sdo_pad_i = pad; sck_i = 1'b0; sdi_i = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Drive one frame of nbits bits; push the expected read byte if any
    task automatic send(input logic [23:0] w, input int nbits,
                        input bit expect_rd, input logic [7:0] exp, input string tag);
        if (expect_rd) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        cs_n_i = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi_i = (i < 24) ? w[23-i] : 1'b0;
            repeat (8) @(negedge clk);
            sck_i = 1'b1;
            repeat (8) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n_i = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // Monitor: capture enabled sdo bits at sck rises, compare per byte
    initial begin
        int         nb = 0;
        logic [7:0] cap = '0;
        forever begin
            @(posedge sck_i or posedge cs_n_i);
            if (cs_n_i === 1'b1) begin
                nb = 0;
            end else if (sdo_oe_o === 1'b1) begin
                oe_seen = 1'b1;
                cap = {cap[6:0], sdo_o};
                nb++;
                if (nb == 8) begin
                    if (exp_q.size() == 0) begin
                        chk("R8 unexpected read output", 32'(cap), 32'hFFFF_FFFF);
                    end else begin
                        chk(tag_q.pop_front(), 32'(cap), 32'(exp_q.pop_front()));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        // R1 R2 R10: host-mode reset state
        do_reset(1'b1, 1'b0);
        set_defaults();
        chk("R2 host mode after reset", 32'(standalone_o), 32'd0);
        check_bank("R1 default value");
        chk("R10 oe idle", 32'(sdo_oe_o), 32'd0);

        // R5: write every register
        for (int i = 0; i < NREG; i++) begin
            d = 8'(8'h5A + i * 37);
            send({8'h08, 8'(i), d}, 24, 1'b0, 8'h00, "");
            model[i] = d;
            check_bank("R5 write commit");
        end

        // R4 R8 R11: read back each register, host sends 0xFF as data
        for (int i = 0; i < NREG; i++) begin
            send({8'h09, 8'(i), 8'hFF}, 24, 1'b1, model[i], "R4 R8 read data");
            check_bank("R11 read leaves bank");
        end
        chk("R10 oe idle after reads", 32'(sdo_oe_o), 32'd0);

        // R9: out-of-range write and read
        send({8'h08, 8'h08, 8'hEE}, 24, 1'b0, 8'h00, "");
        send({8'h08, 8'hFF, 8'hEE}, 24, 1'b0, 8'h00, "");
        check_bank("R9 out-of-range write");
        send({8'h09, 8'h20, 8'hFF}, 24, 1'b1, 8'h00, "R9 out-of-range read");

        // R7: wrong device address
        send({8'h0A, 8'h02, 8'hFF}, 24, 1'b0, 8'h00, "");
        check_bank("R7 wrong address write");
        oe_seen = 1'b0;
        send({8'h0B, 8'h02, 8'hFF}, 24, 1'b0, 8'h00, "");
        chk("R7 wrong address read no drive", 32'(oe_seen), 32'd0);

        // R6: short and long frames
        send({8'h08, 8'h03, 8'h00}, 23, 1'b0, 8'h00, "");
        check_bank("R6 short frame");
        send({8'h08, 8'h03, 8'h00}, 25, 1'b0, 8'h00, "");
        check_bank("R6 long frame");
        send({8'h08, 8'h03, 8'h00}, 16, 1'b0, 8'h00, "");
        check_bank("R6 two-byte frame");

        // R5 R8: port still works after rejected frames
        send({8'h08, 8'h03, 8'hC3}, 24, 1'b0, 8'h00, "");
        model[3] = 8'hC3;
        check_bank("R5 write after rejects");
        send({8'h09, 8'h03, 8'h00}, 24, 1'b1, 8'hC3, "R8 read after rejects");
        chk("R8 all reads answered", 32'(exp_q.size()), 32'd0);

        // R2 R3: standalone with master-select strap high
        do_reset(1'b0, 1'b1);
        set_defaults();
        model[0] = model[0] | 8'h80;
        model[6] = model[6] | 8'h01;
        chk("R2 standalone after reset", 32'(standalone_o), 32'd1);
        check_bank("R3 standalone overrides");
        oe_seen = 1'b0;
        send({8'h08, 8'h02, 8'hAA}, 24, 1'b0, 8'h00, "");
        send({8'h09, 8'h01, 8'h00}, 24, 1'b0, 8'h00, "");
        check_bank("R3 standalone ignores frames");
        chk("R3 standalone no drive", 32'(oe_seen), 32'd0);

        // R3: standalone with master-select strap low
        do_reset(1'b0, 1'b0);
        set_defaults();
        model[0] = model[0] | 8'h80;
        check_bank("R3 standalone strap low");

        // R1 R2: back to host mode
        do_reset(1'b1, 1'b1);
        set_defaults();
        chk("R2 host mode again", 32'(standalone_o), 32'd0);
        check_bank("R1 defaults again");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule